// File: doc/BRIEF.md
# Byte-Lane Static Memory Control Model

This block is a clocked behavioural model of an asynchronous static memory that stores 16-bit words and lets each of its two byte lanes be selected on its own. It turns the chip enable, write enable, output enable and the two active-low lane enables into per-lane write strobes and per-lane drive strobes. It writes the selected lanes of the addressed word. For a read, it returns each selected lane on the output bus with an output-enable flag per lane. A tristate pad would use that flag, and a lane whose flag is low must float.

The address port is 18 bits wide. A depth parameter sets how many words are really stored, and only the low-order address bits that the depth needs take part in indexing. This keeps simulation models small.

The analog access time is modelled as a fixed read latency in clock cycles. Write strobes take effect on the clock edge that samples them.

Top module: `bytelane_sram`

## Requirements
- R1: When ce_n=0 and we_n=0 at a rising edge, bits 7:0 of din are stored into the addressed word if lb_n=0, and bits 15:8 of din are stored if ub_n=0. A read sampled on any later edge returns the new data.
- R2: During a write, a lane whose enable (lb_n for bits 7:0, ub_n for bits 15:8) is high keeps its previous contents unchanged.
- R3: A read is decoded when ce_n=0, oe_n=0 and we_n=1. In that case dout_oe[0] is high and dout[7:0] carries the stored low byte exactly when lb_n=0. dout_oe[1] is high and dout[15:8] carries the stored high byte exactly when ub_n=0.
- R4: Both bits of dout_oe are low for the cycle of any sampled input with ce_n=1, oe_n=1, or lb_n=ub_n=1.
- R5: When we_n=0, the write takes priority over oe_n. Both bits of dout_oe are low even with oe_n=0, and the write of R1 still occurs.
- R6: dout and dout_oe reflect the inputs sampled on rising edge k right after rising edge k+RD_LAT-1 (RD_LAT ≥ 1, default 2). Every cycle of input produces one cycle of output in order.
- R7: The dout bits of a lane whose dout_oe bit is low read as zero.
- R8: Only address bits below log2(DEPTH) select a word. DEPTH must be a power of two and defaults to 1024. Addresses that differ only in higher bits reach the same word.
- R9: A rising edge with rst_n=0 clears dout and dout_oe to zero in all read stages. Stored words are not altered by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read stages |
| addr | input | 18 | Word address |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Low byte lane (bits 7:0) enable, active low |
| ub_n | input | 1 | High byte lane (bits 15:8) enable, active low |
| din | input | 16 | Write data from the bus |
| dout | output | 16 | Read data toward the bus |
| dout_oe | output | 2 | Per-lane drive enable: bit 0 for bits 7:0, bit 1 for bits 15:8 |

## Verification
Every input cycle, including writes and idle cycles, yields an expected output word and an expected lane-enable pair. Both are due RD_LAT rising edges after the inputs are applied, so they are sampled on the falling edge that follows rising edge k+RD_LAT-1. The bench keeps its expected values in a queue RD_LAT entries deep, shifted once per cycle. Each output is compared to the entry issued RD_LAT cycles earlier, and the bench never advances more than one clock per input. A write updates the bench's reference array at issue time, because any read issued afterwards is sampled on a later edge than the write. After a reset the queue is refilled with zero entries, matching the cleared read stages.

// File: rtl/sram_pkg.sv
// Shared types for the byte-lane static memory model.
// Assumes exactly two byte lanes of eight bits each on a 16-bit word.
package sram_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;

    // Per-lane strobes produced by the truth-table decode
    typedef struct packed {
        logic [LANES-1:0] wr;
        logic [LANES-1:0] rd;
    } lane_ctl_t;
endpackage

// File: rtl/sram_decode.sv
// Truth-table decode: turns the active-low control pins into per-lane
// write and drive strobes. A write masks any read, and a deselected chip
// produces no strobe. Purely combinational.
module sram_decode
    import sram_pkg::*;
(
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] lane_n,
    output lane_ctl_t        ctl
);
    logic sel;
    logic wr_cyc;
    logic rd_cyc;

    // Cycle classification from chip, write and output enables
    always_comb begin
        sel    = !ce_n;
        wr_cyc = sel && !we_n;
        rd_cyc = sel && we_n && !oe_n;
    end

    // Lane strobes gated by the per-lane enables
    always_comb begin
        ctl.wr = {LANES{wr_cyc}} & ~lane_n;
        ctl.rd = {LANES{rd_cyc}} & ~lane_n;
    end
endmodule

// File: rtl/sram_array.sv
// Storage split into one byte-wide array per lane, plus the first read
// register. Writes land on the sampling edge. The read register holds zero
// for an undriven lane. Assumes IDX_W bits address DEPTH words exactly.
module sram_array #(
    parameter int DEPTH  = 1024,
    parameter int IDX_W  = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        idx,
    input  logic [LANES-1:0]        wr,
    input  logic [LANES-1:0]        rd,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] rd_q,
    output logic [LANES-1:0]        rd_oe
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Lane store: written only when its strobe is set
        always_ff @(posedge clk) begin
            if (wr[g]) begin
                mem[idx] <= din[g*LANE_W +: LANE_W];
            end
        end

        // Lane read register: data when driven, zero otherwise
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q[g*LANE_W +: LANE_W] <= '0;
                rd_oe[g]                 <= 1'b0;
            end else begin
                rd_q[g*LANE_W +: LANE_W] <= rd[g] ? mem[idx] : '0;
                rd_oe[g]                 <= rd[g];
            end
        end
    end
endmodule

// File: rtl/sram_rdpipe.sv
// Delay line that stretches the read path to the configured latency.
// STAGES may be zero, in which case the data passes straight through.
module sram_rdpipe #(
    parameter int STAGES = 1,
    parameter int W      = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (STAGES == 0) begin : g_bypass
        assign q = d;
    end else begin : g_delay
        logic [W-1:0] sr [STAGES];

        // Shift register with synchronous clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < STAGES; i++) sr[i] <= '0;
            end else begin
                sr[0] <= d;
                for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
            end
        end

        assign q = sr[STAGES-1];
    end
endmodule

// File: rtl/bytelane_sram.sv
// Top of the byte-lane static memory model: decode, per-lane storage and
// the read latency line. Assumes DEPTH is a power of two no larger than
// 2**ADDR_W and RD_LAT >= 1. Upper address bits are dropped by truncation.
module bytelane_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DEPTH  = 1024,
    parameter int RD_LAT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce_n,
    input  logic                    we_n,
    input  logic                    oe_n,
    input  logic                    lb_n,
    input  logic                    ub_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic [LANES-1:0]        dout_oe
);
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int DATA_W = LANES * LANE_W;
    localparam int PIPE_W = DATA_W + LANES;

    lane_ctl_t         ctl;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rd_q;
    logic [LANES-1:0]  rd_oe;
    logic [PIPE_W-1:0] pipe_out;

    // Word index from the low-order address bits
    assign idx = IDX_W'(addr);

    sram_decode u_decode (
        .ce_n   (ce_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .lane_n ({ub_n, lb_n}),
        .ctl    (ctl)
    );

    sram_array #(
        .DEPTH  (DEPTH),
        .IDX_W  (IDX_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (idx),
        .wr    (ctl.wr),
        .rd    (ctl.rd),
        .din   (din),
        .rd_q  (rd_q),
        .rd_oe (rd_oe)
    );

    sram_rdpipe #(
        .STAGES (RD_LAT - 1),
        .W      (PIPE_W)
    ) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rd_oe, rd_q}),
        .q     (pipe_out)
    );

    // Split the delayed word into data and lane drive enables
    assign dout    = pipe_out[DATA_W-1:0];
    assign dout_oe = pipe_out[PIPE_W-1:DATA_W];
endmodule

// File: rtl/sram_chk.sv
// Checker for the byte-lane static memory model, attached with bind.
// Relates the pins, the decode strobes and the output word.
module sram_chk
    import sram_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ce_n,
    input logic                    lb_n,
    input logic                    ub_n,
    input lane_ctl_t               ctl,
    input logic [LANES*LANE_W-1:0] dout,
    input logic [LANES-1:0]        dout_oe
);
    // R5: a write strobe never coexists with a drive strobe
    p_write_masks_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.wr != '0) |-> (ctl.rd == '0));

    // R4: a deselected chip raises no strobe
    p_deselect_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (ctl.wr == '0 && ctl.rd == '0));

    // R3: a low-lane strobe requires its lane enable
    p_low_lane_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.wr[0] || ctl.rd[0]) |-> !lb_n);

    // R3: a high-lane strobe requires its lane enable
    p_high_lane_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.wr[1] || ctl.rd[1]) |-> !ub_n);

    // R7: undriven low lane reads zero
    p_low_lane_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe[0] |-> (dout[7:0] == 8'h00));

    // R7: undriven high lane reads zero
    p_high_lane_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe[1] |-> (dout[15:8] == 8'h00));

    // R9: a reset edge leaves the outputs cleared
    p_reset_clears_r9: assert property (@(posedge clk)
        !rst_n |=> (dout_oe == '0 && dout == '0));
endmodule

bind bytelane_sram sram_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .lb_n    (lb_n),
    .ub_n    (ub_n),
    .ctl     (ctl),
    .dout    (dout),
    .dout_oe (dout_oe)
);

// File: tb/bytelane_sram_tb_top.sv
`timescale 1ns/1ps
// Bench for the byte-lane static memory model: directed corner cases and
// seeded random cycles, each compared RD_LAT cycles after issue.
module bytelane_sram_tb_top;
    localparam int ADDR_W = 18;
    localparam int DEPTH  = 1024;
    localparam int RD_LAT = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic              ce_n, we_n, oe_n, lb_n, ub_n;
    logic [15:0]       din;
    logic [15:0]       dout;
    logic [1:0]        dout_oe;

    int checks = 0;
    int fails  = 0;

    logic [15:0] ref_mem [DEPTH];
    logic [1:0]  q_oe  [RD_LAT];
    logic [15:0] q_dat [RD_LAT];
    string       q_tag [RD_LAT];
    logic        q_chk [RD_LAT];

    always #10 clk = ~clk;

    bytelane_sram #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .RD_LAT(RD_LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    // Requirement tag for a cycle from its control pins
    function automatic string tag_of(logic c, logic w, logic o, logic l, logic u);
        if (!c && !w) return o ? "R1" : "R5";
        if (!c && !o && !(l && u)) return "R3 R6";
        return "R4";
    endfunction

    task automatic compare(string tag, logic [1:0] eo, logic [15:0] ed);
        checks++;
        if (dout_oe !== eo || dout !== ed) begin
            fails++;
            $display("FAIL %s: oe=%b dout=%h expected oe=%b dout=%h",
                     tag, dout_oe, dout, eo, ed);
        end
    endtask

    // One input cycle: check the due output, queue this cycle's expectation
    task automatic step(logic c, logic w, logic o, logic l, logic u,
                        logic [ADDR_W-1:0] a, logic [15:0] d, string extra);
        int unsigned ai;
        logic        rd;
        logic [1:0]  eo;
        logic [15:0] ed;
        if (q_chk[RD_LAT-1]) compare(q_tag[RD_LAT-1], q_oe[RD_LAT-1], q_dat[RD_LAT-1]);
        for (int i = RD_LAT - 1; i > 0; i--) begin
            q_oe[i] = q_oe[i-1]; q_dat[i] = q_dat[i-1];
            q_tag[i] = q_tag[i-1]; q_chk[i] = q_chk[i-1];
        end
        ai = int'(a) % DEPTH;
        rd = !c && w && !o;
        eo = {rd && !u, rd && !l};
        ed = {eo[1] ? ref_mem[ai][15:8] : 8'h00, eo[0] ? ref_mem[ai][7:0] : 8'h00};
        q_oe[0] = eo; q_dat[0] = ed; q_chk[0] = 1'b1;
        q_tag[0] = {extra, tag_of(c, w, o, l, u)};
        ce_n = c; we_n = w; oe_n = o; lb_n = l; ub_n = u; addr = a; din = d;
        if (!c && !w) begin
            if (!l) ref_mem[ai][7:0]  = d[7:0];
            if (!u) ref_mem[ai][15:8] = d[15:8];
        end
        @(negedge clk);
    endtask

    task automatic idle_pins();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
        addr = '0; din = '0;
    endtask

    // Hold reset, check cleared outputs, refill the queue with zeros
    task automatic do_reset();
        idle_pins();
        rst_n = 1'b0;
        repeat (RD_LAT + 1) @(negedge clk);
        compare("R9", 2'b00, 16'h0000);
        for (int i = 0; i < RD_LAT; i++) begin
            q_oe[i] = '0; q_dat[i] = '0; q_tag[i] = "R9"; q_chk[i] = 1'b1;
        end
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: cycles=200000 expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h0000_51a7));
        for (int i = 0; i < RD_LAT; i++) q_chk[i] = 1'b0;
        @(negedge clk);
        do_reset();

        // R1: fill every word with both lanes
        for (int i = 0; i < DEPTH; i++)
            step(0, 0, 1, 0, 0, ADDR_W'(i), 16'(i * 40503) ^ 16'h5a5a, "R1 ");

        // R2: single-lane writes keep the other lane
        step(0, 0, 1, 0, 1, 18'd5, 16'hAB12, "R2 ");
        step(0, 1, 0, 0, 0, 18'd5, 16'h0000, "R2 ");
        step(0, 0, 1, 1, 0, 18'd5, 16'h34FF, "R2 ");
        step(0, 1, 0, 0, 0, 18'd5, 16'h0000, "R2 ");
        // R7: single-lane reads zero the other lane
        step(0, 1, 0, 0, 1, 18'd5, 16'h0000, "R7 ");
        step(0, 1, 0, 1, 0, 18'd5, 16'h0000, "R7 ");
        // R4: each float condition
        step(1, 1, 0, 0, 0, 18'd5, 16'h0000, "");
        step(0, 1, 1, 0, 0, 18'd5, 16'h0000, "");
        step(0, 1, 0, 1, 1, 18'd5, 16'h0000, "");
        // R5: write with output enable low, then read back
        step(0, 0, 0, 0, 0, 18'd7, 16'hC0DE, "");
        step(0, 1, 0, 0, 0, 18'd7, 16'h0000, "R5 ");
        // R8: aliased addresses
        step(0, 0, 1, 0, 0, ADDR_W'(DEPTH * 5 + 9), 16'h7777, "R8 ");
        step(0, 1, 0, 0, 0, 18'd9, 16'h0000, "R8 ");
        step(0, 1, 0, 0, 0, ADDR_W'(DEPTH * 200 + 9), 16'h0000, "R8 ");
        // R6: back-to-back reads in order
        step(0, 1, 0, 0, 0, 18'd1, 16'h0000, "R6 ");
        step(0, 1, 0, 0, 0, 18'd2, 16'h0000, "R6 ");
        step(0, 1, 0, 0, 0, 18'd3, 16'h0000, "R6 ");
        // R9: storage survives reset
        step(0, 0, 1, 0, 0, 18'd11, 16'h1111, "R9 ");
        step(1, 1, 1, 1, 1, 18'd0, 16'h0000, "R9 ");
        do_reset();
        step(0, 1, 0, 0, 0, 18'd11, 16'h0000, "R9 ");

        // Seeded random cycles over all pins
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 8) == 0, ($urandom % 3) != 0, ($urandom % 4) == 0,
                 ($urandom % 3) == 0, ($urandom % 3) == 0,
                 ADDR_W'($urandom), 16'($urandom), "");
        end

        // Drain the queue
        for (int n = 0; n < RD_LAT; n++) step(1, 1, 1, 1, 1, 18'd0, 16'h0000, "");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule